// File: doc/BRIEF.md
# Static Branch Prediction and Redirect Unit

This block sits in the early decode stage of an in-order pipeline. Each cycle it looks at the instruction being decoded: its class, its address and its sign-extended displacement. A fixed rule decides whether the branch will be taken. If the prediction is taken, the block sends a flush and a redirect toward fetch and the instruction cache in the same cycle, with the branch target as the new fetch address.

The prediction bit moves into a one-entry stage register together with the instruction. That register feeds the execute stage. When the execute stage resolves the branch, the block compares the real outcome with the prediction that came with the instruction. It sends a corrective redirect only when the two differ. The corrective redirect is registered, so it reaches fetch one cycle after the mismatch is detected. If that corrective redirect lands in the same cycle as a new early prediction, the corrective redirect wins.

Top module: `bp_redirect_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, redirect_o, flush_o, ex_valid_o and ex_pred_o are all 0.
- R2: A valid instruction of class 1 (unconditional relative) is predicted taken. When no corrective redirect is pending, redirect_o and flush_o are 1 in that same cycle.
- R3: A valid instruction of class 2 (conditional relative) is predicted taken if and only if bit ADDR_W-1 of its displacement is 1.
- R4: A valid instruction of class 3 (target taken from a register) is predicted not taken. So is an instruction of class 0 (not a branch), and so is any instruction with dec_valid_i low. None of these raises an early redirect.
- R5: The early redirect address is dec_pc_i + dec_offset_i with bits 1:0 forced to 0.
- R6: One cycle after a valid decode, ex_valid_o is 1 and ex_pred_o carries that instruction's prediction. The exception is when the instruction is squashed (R10).
- R7: A corrective redirect is raised exactly one cycle after a cycle in which ex_valid_o is 1, the staged class is nonzero and ex_taken_i differs from ex_pred_o. In no other case is a corrective redirect raised.
- R8: The corrective address depends on the direction of the error. When the branch was predicted taken but not taken, the address is the staged address + 4. When it was predicted not taken but taken, the address is the staged computed target for classes 1 and 2, and the ex_reg_target_i value sampled at resolution for class 3.
- R9: When a corrective redirect and an early prediction fall in the same cycle, redirect_addr_o carries the corrective address.
- R10: An instruction decoded in the cycle a mismatch is detected, or in the cycle the corrective redirect is issued, does not enter the stage register: ex_valid_o is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dec_valid_i | input | 1 | Decode slot holds an instruction |
| dec_class_i | input | 2 | 0 none, 1 unconditional relative, 2 conditional relative, 3 register target |
| dec_pc_i | input | ADDR_W | Instruction address |
| dec_offset_i | input | ADDR_W | Sign-extended displacement |
| ex_taken_i | input | 1 | Resolved outcome of the staged instruction |
| ex_reg_target_i | input | ADDR_W | Register-sourced target of the staged instruction |
| redirect_o | output | 1 | Fetch redirect request |
| flush_o | output | 1 | Upstream flush request |
| redirect_addr_o | output | ADDR_W | New fetch address |
| ex_valid_o | output | 1 | Stage register holds a live instruction |
| ex_pred_o | output | 1 | Prediction tag of the staged instruction |

## Verification
The corrective redirect and an early taken prediction can both fall in the same cycle. To provoke this, the bench stages a branch whose outcome disagrees with its prediction, then decodes an unconditional branch one cycle after the resolution cycle. The unconditional branch would raise an early redirect, but the corrective redirect is already pending in that cycle. The bench judges the collision by checking that redirect_addr_o carries the corrective address rather than the early target, and that the colliding instruction is dropped from the stage register.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CLS_NONE     = 2'd0,
    CLS_UNCOND   = 2'd1,
    CLS_COND     = 2'd2,
    CLS_INDIRECT = 2'd3
  } br_class_e;
endpackage

// File: rtl/bp_rule.sv
module bp_rule
  import bp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic              valid_i,
  input  br_class_e         cls_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] offset_i,
  output logic              pred_o,
  output logic [ADDR_W-1:0] target_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << ALIGN_BITS) - 1);

  logic backward;
  assign backward = offset_i[ADDR_W-1];

  always_comb begin
    pred_o = 1'b0;
    if (valid_i) begin
      unique case (cls_i)
        CLS_UNCOND: pred_o = 1'b1;
        CLS_COND:   pred_o = backward;
        default:    pred_o = 1'b0;
      endcase
    end
  end

  assign target_o = (pc_i + offset_i) & ALIGN_MASK;
endmodule

// File: rtl/bp_resolve.sv
module bp_resolve
  import bp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_valid_i,
  input  br_class_e         dec_class_i,
  input  logic [ADDR_W-1:0] dec_pc_i,
  input  logic [ADDR_W-1:0] dec_target_i,
  input  logic              dec_pred_i,
  input  logic              ex_taken_i,
  input  logic [ADDR_W-1:0] ex_reg_target_i,
  output logic              ex_valid_o,
  output logic              ex_pred_o,
  output logic              mispredict_o,
  output logic              late_fire_o,
  output logic [ADDR_W-1:0] late_addr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic              v_q, pred_q, late_q;
  br_class_e         cls_q;
  logic [ADDR_W-1:0] pc_q, tgt_q, late_addr_q, fix_addr;

  assign mispredict_o = v_q && (cls_q != CLS_NONE) && (ex_taken_i != pred_q);

  always_comb begin
    if (pred_q)                      fix_addr = pc_q + STEP;
    else if (cls_q == CLS_INDIRECT)  fix_addr = ex_reg_target_i;
    else                             fix_addr = tgt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q         <= 1'b0;
      pred_q      <= 1'b0;
      cls_q       <= CLS_NONE;
      pc_q        <= '0;
      tgt_q       <= '0;
      late_q      <= 1'b0;
      late_addr_q <= '0;
    end else begin
      // wrong-path slots never enter the stage
      v_q         <= dec_valid_i && !mispredict_o && !late_q;
      pred_q      <= dec_pred_i;
      cls_q       <= dec_class_i;
      pc_q        <= dec_pc_i;
      tgt_q       <= dec_target_i;
      late_q      <= mispredict_o;
      late_addr_q <= fix_addr;
    end
  end

  assign ex_valid_o  = v_q;
  assign ex_pred_o   = v_q && pred_q;
  assign late_fire_o = late_q;
  assign late_addr_o = late_addr_q;
endmodule

// File: rtl/bp_redirect_unit.sv
module bp_redirect_unit
  import bp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_valid_i,
  input  logic [1:0]        dec_class_i,
  input  logic [ADDR_W-1:0] dec_pc_i,
  input  logic [ADDR_W-1:0] dec_offset_i,
  input  logic              ex_taken_i,
  input  logic [ADDR_W-1:0] ex_reg_target_i,
  output logic              redirect_o,
  output logic              flush_o,
  output logic [ADDR_W-1:0] redirect_addr_o,
  output logic              ex_valid_o,
  output logic              ex_pred_o
);
  localparam int ALIGN_BITS = $clog2(INSN_BYTES);

  br_class_e         cls;
  logic              pred, early_fire, mispredict, late_fire;
  logic [ADDR_W-1:0] target, late_addr;

  assign cls = br_class_e'(dec_class_i);

  bp_rule #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) i_rule (
    .valid_i  (dec_valid_i),
    .cls_i    (cls),
    .pc_i     (dec_pc_i),
    .offset_i (dec_offset_i),
    .pred_o   (pred),
    .target_o (target)
  );

  bp_resolve #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) i_resolve (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .dec_valid_i     (dec_valid_i),
    .dec_class_i     (cls),
    .dec_pc_i        (dec_pc_i),
    .dec_target_i    (target),
    .dec_pred_i      (pred),
    .ex_taken_i      (ex_taken_i),
    .ex_reg_target_i (ex_reg_target_i),
    .ex_valid_o      (ex_valid_o),
    .ex_pred_o       (ex_pred_o),
    .mispredict_o    (mispredict),
    .late_fire_o     (late_fire),
    .late_addr_o     (late_addr)
  );

  // late correction outranks early prediction
  assign early_fire      = pred && !late_fire;
  assign redirect_o      = early_fire || late_fire;
  assign flush_o         = redirect_o;
  assign redirect_addr_o = late_fire ? late_addr : target;
endmodule

// File: rtl/bp_redirect_chk.sv
module bp_redirect_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dec_valid_i,
  input logic [1:0]        dec_class_i,
  input logic              ex_taken_i,
  input logic              redirect_o,
  input logic              flush_o,
  input logic [ADDR_W-1:0] redirect_addr_o,
  input logic              ex_valid_o,
  input logic              ex_pred_o,
  input logic              mispredict,
  input logic              late_fire,
  input logic [ADDR_W-1:0] stage_pc
);
  p_uncond_redirect_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && dec_class_i == 2'd1) |-> (redirect_o && flush_o));

  p_indirect_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!late_fire && (!dec_valid_i || dec_class_i == 2'd3 || dec_class_i == 2'd0)) |-> !redirect_o);

  p_early_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !late_fire) |-> (redirect_addr_o[1:0] == 2'b00));

  p_late_after_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_o && dec_class_i != 2'd1 && ex_pred_o && !ex_taken_i) |=>
      (redirect_o && redirect_addr_o == $past(stage_pc) + ADDR_W'(4)));

  p_tag_forward_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !mispredict && !late_fire) |=> ex_valid_o);

  p_squash_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_fire |-> !ex_valid_o);

  p_pred_needs_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_pred_o |-> ex_valid_o);
endmodule

bind bp_redirect_unit bp_redirect_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .dec_valid_i     (dec_valid_i),
  .dec_class_i     (dec_class_i),
  .ex_taken_i      (ex_taken_i),
  .redirect_o      (redirect_o),
  .flush_o         (flush_o),
  .redirect_addr_o (redirect_addr_o),
  .ex_valid_o      (ex_valid_o),
  .ex_pred_o       (ex_pred_o),
  .mispredict      (mispredict),
  .late_fire       (late_fire),
  .stage_pc        (i_resolve.pc_q)
);

// File: tb/test_bp_redirect_unit.sv
module test_bp_redirect_unit;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dv = 1'b0;
  logic [1:0]    dcls = 2'd0;
  logic [AW-1:0] dpc = '0, doff = '0, rtgt = '0;
  logic          tk = 1'b0;
  logic          redir, flush, exv, exp_o;
  logic [AW-1:0] raddr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model state
  bit            m_v, m_pred, m_late;
  logic [1:0]    m_cls;
  logic [AW-1:0] m_pc, m_tgt, m_laddr;

  always #10 clk = ~clk;

  bp_redirect_unit #(.ADDR_W(AW)) i_bp_redirect_unit (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dv), .dec_class_i(dcls),
    .dec_pc_i(dpc), .dec_offset_i(doff), .ex_taken_i(tk), .ex_reg_target_i(rtgt),
    .redirect_o(redir), .flush_o(flush), .redirect_addr_o(raddr),
    .ex_valid_o(exv), .ex_pred_o(exp_o)
  );

  function automatic bit f_pred(bit v, logic [1:0] c, logic [AW-1:0] off);
    return v && (c == 2'd1 || (c == 2'd2 && off[AW-1]));
  endfunction

  function automatic logic [AW-1:0] f_tgt(logic [AW-1:0] pc, logic [AW-1:0] off);
    return (pc + off) & ~AW'(3);
  endfunction

  task automatic chk(bit ok, string tag, logic [AW-1:0] act, logic [AW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // drive at negedge, check mid-low, then advance model to next edge
  task automatic step(bit v, logic [1:0] c, logic [AW-1:0] pc, logic [AW-1:0] off,
                      bit t, logic [AW-1:0] rt, string extra);
    bit pr, e_red, mis;
    logic [AW-1:0] tg, e_addr, fix;
    string tag_r, tag_a;
    @(negedge clk);
    dv = v; dcls = c; dpc = pc; doff = off; tk = t; rtgt = rt;
    #5;
    pr = f_pred(v, c, off);
    tg = f_tgt(pc, off);
    e_red  = m_late || pr;
    e_addr = m_late ? m_laddr : tg;
    tag_r = m_late ? "R7" : (c == 2'd1 ? "R2" : (c == 2'd2 ? "R3" : "R4"));
    tag_a = (extra != "") ? extra : (m_late ? "R8" : "R5");
    chk(redir == e_red, tag_r, AW'(redir), AW'(e_red));
    chk(flush == e_red, tag_r, AW'(flush), AW'(e_red));
    if (e_red) chk(raddr == e_addr, tag_a, raddr, e_addr);
    chk(exv == m_v, m_late ? "R10" : "R6", AW'(exv), AW'(m_v));
    chk(exp_o == (m_v && m_pred), "R6", AW'(exp_o), AW'(m_v && m_pred));
    mis = m_v && m_cls != 2'd0 && (t != m_pred);
    fix = m_pred ? m_pc + AW'(4) : (m_cls == 2'd3 ? rt : m_tgt);
    m_v = v && !mis && !m_late;
    m_late = mis; m_laddr = fix;
    m_cls = c; m_pc = pc; m_tgt = tg; m_pred = pr;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_v = 0; m_pred = 0; m_late = 0; m_cls = 0; m_pc = 0; m_tgt = 0; m_laddr = 0;
    #25;
    chk(!redir && !flush && !exv && !exp_o, "R1", AW'({redir, flush, exv, exp_o}), '0);
    @(negedge clk); rst_n = 1'b1;
    #5;
    chk(!redir && !exv && !exp_o, "R1", AW'({redir, exv, exp_o}), '0);
    // directed
    step(1, 2'd1, 32'h1000, 32'h0000_0040, 1, 0, "");  // R2 uncond taken
    step(1, 2'd2, 32'h2000, 32'h0000_0010, 1, 0, "");  // resolves match; R3 fwd cond
    step(1, 2'd2, 32'h3000, 32'hFFFF_FFF0, 1, 0, "");  // prev cond pred NT, taken -> R8 target
    step(1, 2'd0, 32'h3004, 32'h0, 0, 0, "");           // R10 squash, late fire
    step(1, 2'd3, 32'h4000, 32'h0, 0, 0, "");           // R4 indirect
    step(1, 2'd0, 32'h4004, 32'h0, 1, 32'h8888, "");    // indirect mispredict -> reg target
    step(0, 2'd0, 32'h0, 32'h0, 0, 0, "R8");
    step(1, 2'd1, 32'h5000, 32'h0000_0103, 0, 0, "R5"); // unaligned offset
    step(0, 2'd0, 32'h0, 32'h0, 0, 0, "");              // taken pred, not taken -> pc+4
    step(1, 2'd1, 32'h6000, 32'h0000_0200, 1, 0, "R9"); // collision with late redirect
    step(0, 2'd0, 32'h0, 32'h0, 0, 0, "");
    step(1, 2'd2, 32'h7000, 32'h0000_0020, 0, 0, "");   // R7 match, no late
    step(0, 2'd0, 32'h0, 32'h0, 0, 0, "");
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] off;
      off = AW'($signed(12'($urandom)));
      step(($urandom % 4) != 0, 2'($urandom), {$urandom} & ~AW'(3), off,
           1'($urandom), {$urandom} & ~AW'(3), "");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule